// File: doc/BRIEF.md
# Segmented Scan Shift Clock Gate

This block drives the clocks of a scan chain that has been cut into a number of segments. All segments share one scan input and one scan output and are stitched end to end. The result still behaves as one long chain, but only one segment toggles in any shift cycle. Every segment clock is a gated copy of the one system clock, so no second clock source is needed. Each gate is a latch-held enable, and the latch is transparent only while the clock is low.

When scan enable is high, the tester pulses `start` with a segment length L. The block then gives exactly L shift pulses to each segment in turn. It begins with the highest-numbered segment, which sits next to the scan output, and moves down to segment 0. After NUM_SEG*L pulses it raises `shift_done`. This is the same number of shift cycles as an unsegmented chain of the same total length, so shift power per cycle drops by about the number of segments. When scan enable is low (capture), every segment clock runs on every edge.

Top module: `seg_scan_clk_gate`

## Requirements
- R1: After reset with scan enable high, all segment enables are 0, `shift_done` is 0 and `cur_seg` equals NUM_SEG-1.
- R2: While `shift_en` is 0, every bit of `seg_clk_en` is 1 in the same cycle.
- R3: While `shift_en` is 1, at most one bit of `seg_clk_en` is 1.
- R4: During a shift run, segments are clocked in descending order, starting at NUM_SEG-1 and ending at 0. When a segment is active, `cur_seg` holds its index and its enable bit is the one that is set.
- R5: A run started with length L>0 gives exactly L enabled cycles to every segment. `shift_done` rises in the cycle after the last of the NUM_SEG*L enabled cycles, and `cur_seg` is then 0.
- R6: A `start` pulse that arrives while a run is in progress has no effect.
- R7: A `start` with `seg_len` equal to 0 sets `shift_done` on the next cycle and enables no segment.
- R8: Dropping `shift_en` during a run ends the run and clears `shift_done`, and `cur_seg` keeps its value. Raising `shift_en` again leaves every enable at 0 until the next `start`.
- R9: Each gated clock `seg_clk[i]` is 0 while `clk` is low. While `clk` is high, it equals the enable that was present just before the rising edge.
- R10: `shift_done` stays at 1 until the next accepted `start` or until `shift_en` falls. A new `start` after completion begins a new run.
- R11: The segment length is captured at `start`. Changes to `seg_len` during a run do not alter the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | Scan enable: 1 = shift, 0 = capture |
| start | input | 1 | Single-cycle request to begin a shift run |
| seg_len | input | LEN_W | Shift pulses per segment, sampled at start |
| seg_clk_en | output | NUM_SEG | Per-segment clock enable for the current cycle |
| seg_clk | output | NUM_SEG | Glitch-free gated segment clocks |
| shift_done | output | 1 | All segments have been shifted |
| cur_seg | output | $clog2(NUM_SEG) | Index of the segment being shifted |

## Verification
The bench builds the block with NUM_SEG=3 and LEN_W=4. Three segments is not a power of two, so the 2-bit index never reaches its unused code 3, and the descending order from 2 down to 0 is fully exercised. A 4-bit length allows runs of length 1, 4 and the maximum 15, as well as the zero-length case. This covers both single-pulse segments and a 45-cycle run within a short simulation. A reference model counts pulses and is compared every cycle. It covers capture cycles, a start and a length change during a run, and an abort by dropping scan enable.

// File: rtl/seg_scan_clk_gate.sv
module seg_scan_clk_gate #(
  parameter int NUM_SEG = 4,
  parameter int LEN_W   = 8,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               start,
  input  logic [LEN_W-1:0]   seg_len,
  output logic [NUM_SEG-1:0] seg_clk_en,
  output logic [NUM_SEG-1:0] seg_clk,
  output logic               shift_done,
  output logic [SEG_W-1:0]   cur_seg
);
  localparam logic [SEG_W-1:0] LAST = SEG_W'(NUM_SEG - 1);

  logic             busy, done_q;
  logic [SEG_W-1:0] cur;
  logic [LEN_W-1:0] cnt, len_q;

  wire seg_end = (cnt == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      cur    <= LAST;
      cnt    <= '0;
      len_q  <= '0;
    end else if (!shift_en) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
    end else if (busy) begin
      if (seg_end) begin
        cnt <= '0;
        if (cur == '0) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cur <= cur - 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start) begin
      cnt <= '0;
      if (seg_len == '0) begin
        done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
        busy   <= 1'b1;
        cur    <= LAST;
        len_q  <= seg_len;
      end
    end
  end

  assign shift_done = done_q;
  assign cur_seg    = cur;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic en_lat;
    assign seg_clk_en[g] = !shift_en || (busy && (cur == SEG_W'(g)));
    always_latch begin
      if (!clk) en_lat = seg_clk_en[g];
    end
    assign seg_clk[g] = clk & en_lat;
  end
endmodule

module seg_scan_clk_gate_chk #(
  parameter int NUM_SEG = 4,
  parameter int LEN_W   = 8,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shift_en,
  input logic               start,
  input logic [LEN_W-1:0]   seg_len,
  input logic [NUM_SEG-1:0] seg_clk_en,
  input logic               shift_done,
  input logic [SEG_W-1:0]   cur_seg
);
  p_capture_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |-> (&seg_clk_en));

  p_one_segment_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> $onehot0(seg_clk_en));

  p_index_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && (|seg_clk_en)) |-> seg_clk_en[cur_seg]);

  p_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && (|seg_clk_en)) |=>
      (!shift_en || cur_seg == $past(cur_seg) || cur_seg == $past(cur_seg) - 1'b1));

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done && shift_en) |-> (seg_clk_en == '0));

  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && start && seg_len == '0 && seg_clk_en == '0) |=> shift_done);

  p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> !shift_done);
endmodule

bind seg_scan_clk_gate seg_scan_clk_gate_chk #(.NUM_SEG(NUM_SEG), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .start(start), .seg_len(seg_len),
  .seg_clk_en(seg_clk_en), .shift_done(shift_done), .cur_seg(cur_seg)
);

// File: tb/test_seg_scan_clk_gate.sv
module test_seg_scan_clk_gate;
  localparam int NS = 3;
  localparam int LW = 4;
  localparam int SW = $clog2(NS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b1;
  logic start = 1'b0;
  logic [LW-1:0] seg_len = 4'd4;
  logic [NS-1:0] seg_clk_en, seg_clk;
  logic shift_done;
  logic [SW-1:0] cur_seg;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seg_scan_clk_gate #(.NUM_SEG(NS), .LEN_W(LW)) i_seg_scan_clk_gate (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .start(start), .seg_len(seg_len),
    .seg_clk_en(seg_clk_en), .seg_clk(seg_clk), .shift_done(shift_done), .cur_seg(cur_seg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: counts pulses of the run
  int m_busy = 0, m_done = 0, m_pulses = 0, m_len = 0, m_cur = NS - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pulses = 0; m_len = 0; m_cur = NS - 1;
    end else if (!shift_en) begin
      m_busy = 0; m_done = 0;
    end else if (m_busy != 0) begin
      m_pulses++;
      if (m_pulses == NS * m_len) begin
        m_busy = 0; m_done = 1; m_cur = 0;
      end else begin
        m_cur = NS - 1 - m_pulses / m_len;
      end
    end else if (start) begin
      m_pulses = 0;
      if (seg_len == 0) m_done = 1;
      else begin
        m_done = 0; m_busy = 1; m_len = int'(seg_len); m_cur = NS - 1;
      end
    end
  end

  function automatic logic [NS-1:0] exp_en();
    logic [NS-1:0] e = '0;
    if (!shift_en) e = '1;
    else if (m_busy != 0) e[m_cur] = 1'b1;
    return e;
  endfunction

  logic [NS-1:0] last_en;
  bit            last_valid = 0;
  int            seg_cnt [NS];
  int            first_seg = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NS-1:0] e;
      string t;
      e = exp_en();
      t = !shift_en ? "R2 capture enables" : (m_busy != 0 ? "R3/R4 shift enable" : "R8/R10 idle enable");
      chk(seg_clk_en == e, t, int'(seg_clk_en), int'(e));
      chk(shift_done == m_done[0], "R5/R10 shift_done", int'(shift_done), m_done);
      chk(int'(cur_seg) == m_cur, "R4 cur_seg", int'(cur_seg), m_cur);
      if (shift_en) begin
        for (int s = 0; s < NS; s++)
          if (seg_clk_en[s]) begin
            seg_cnt[s]++;
            if (first_seg < 0) first_seg = s;
          end
      end
      last_en = seg_clk_en;
      last_valid = 1;
      #1;
      chk(seg_clk == '0, "R9 gated clock low phase", int'(seg_clk), 0);
    end
  end

  always @(posedge clk) begin
    if (rst_n && last_valid) begin
      #3;
      chk(seg_clk == last_en, "R9 gated clock high phase", int'(seg_clk), int'(last_en));
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic run(input int len, input bit poke);
    for (int s = 0; s < NS; s++) seg_cnt[s] = 0;
    first_seg = -1;
    seg_len = LW'(len);
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    for (int i = 0; i < 200 && !shift_done; i++) begin
      if (poke && i == 2) begin start = 1'b1; seg_len = LW'(len + 2); end   // R6, R11
      else start = 1'b0;
      cyc(1);
    end
    start = 1'b0;
    chk(shift_done == 1'b1, "R5 done reached", int'(shift_done), 1);
    for (int s = 0; s < NS; s++)
      chk(seg_cnt[s] == len, poke ? "R6/R11 pulses per segment" : "R5 pulses per segment",
          seg_cnt[s], len);
    if (len > 0) chk(first_seg == NS - 1, "R4 first segment", first_seg, NS - 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk(seg_clk_en == '0, "R1 reset enables", int'(seg_clk_en), 0);
    chk(shift_done == 1'b0, "R1 reset done", int'(shift_done), 0);
    chk(int'(cur_seg) == NS - 1, "R1 reset index", int'(cur_seg), NS - 1);
    rst_n = 1'b1;
    cyc(2);
    shift_en = 1'b0;                       // R2 capture
    cyc(4);
    shift_en = 1'b1;
    cyc(2);
    run(4, 1'b1);                          // R5, R6, R11
    cyc(5);                                // R10 done holds
    chk(shift_done == 1'b1, "R10 done persists", int'(shift_done), 1);
    run(1, 1'b0);                          // R10 restart
    run(15, 1'b0);
    run(0, 1'b0);                          // R7
    cyc(2);
    seg_len = 4'd5; start = 1'b1; cyc(1); start = 1'b0;
    cyc(7);
    shift_en = 1'b0;                       // R8 abort
    cyc(2);
    chk(shift_done == 1'b0, "R8 abort clears done", int'(shift_done), 0);
    start = 1'b1; cyc(1); start = 1'b0;    // start in capture ignored
    shift_en = 1'b1;
    cyc(3);
    chk(seg_clk_en == '0, "R8 idle after abort", int'(seg_clk_en), 0);
    run(2, 1'b0);
    cyc(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule